// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit integer core that completes one instruction per clock. In a single period it fetches a word at the program counter, reads two registers, runs the ALU, optionally touches data memory and then selects the value to write back. The next-PC choice is made in the same period. It covers register-to-register arithmetic and logic, word loads and stores addressed as base register plus signed offset, and a branch taken when two registers are equal.

Instruction memory and data memory sit outside the core as two separate arrays. Both read combinationally and write on the clock edge, so one fetch and one data access can happen in the same period. The fetch and data ports are plain address/data pins with no handshake. A memory that stalls is not supported: each port must return its data within the same cycle. Every piece of state is written on the rising edge that closes the cycle: the PC, the register file, and data memory through the write strobe.

Top module: `sc_core`

## Requirements
- R1: `rst` is synchronous and active high. Any edge with `rst` high loads the PC with 0, and while `rst` is high `dmem_we` stays low and no register is written.
- R2: An instruction that is not a taken branch advances the PC by 4 at the closing edge.
- R3: Opcode field [31:26] = 0x00 selects a register operation on rs [25:21] and rt [20:16], with the result written to rd [15:11]. Function field [5:0] values: 0x20 add, 0x22 subtract (rs minus rt), 0x24 bitwise and, 0x25 bitwise or, 0x2A signed less-than giving 1 or 0. Arithmetic wraps modulo 2^32.
- R4: Opcode 0x23 loads a word. The address is rs plus the 16-bit immediate [15:0] sign-extended to 32 bits. `dmem_rdata` is written to register rt.
- R5: Opcode 0x2B stores a word. In that cycle `dmem_we` is high, `dmem_addr` is rs plus the sign-extended immediate, and `dmem_wdata` is register rt. No register is written. `dmem_we` is high for no other opcode.
- R6: Opcode 0x04 compares rs and rt. When they are equal, the next PC is PC + 4 + (sign-extended immediate × 4). Otherwise it is PC + 4. No register or memory write takes place.
- R7: Register 0 always reads as zero, and any write to it is discarded.
- R8: An opcode other than 0x00, 0x04, 0x23 or 0x2B, or a function value not listed in R3, writes nothing and only advances the PC by 4.
- R9: An instruction that reads the same register it writes sees the old value. The next instruction sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for a load or store (ALU result) |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_we | output | 1 | Store strobe; memory writes at the closing edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |

## Verification
The register file can be written and read in the same cycle, and that is where a timing error would show. A chain such as "load r1; add r1,r1,r1; add r2,r1,r1" has one instruction read the register it is writing, and the next instruction read the result. Both results are stored to memory and compared with 2a and 4a. The same check applies to branches: a branch depends on two registers loaded in the two preceding cycles. Register values are made visible only through stores. The ALU sweep covers every operation over a set of edge operand values.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    mem_we;
    logic    is_branch;
    alu_fn_e alu_fn;
  } ctrl_t;
endpackage

// File: rtl/sc_regfile.sv
module sc_regfile import sc_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic [REG_AW-1:0] ra_idx,
  input  logic [REG_AW-1:0] rb_idx,
  output logic [XLEN-1:0]   ra_val,
  output logic [XLEN-1:0]   rb_val,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_val
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx == REG_AW'(i)))
          regs[i] <= wr_val;
      end
    end
  end

  assign ra_val = regs[ra_idx];
  assign rb_val = regs[rb_idx];
endmodule

// File: rtl/sc_alu.sv
module sc_alu import sc_pkg::*; #(
  parameter int XLEN = 32
) (
  input  alu_fn_e         fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_decode.sv
module sc_decode import sc_pkg::*; (
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  alu_fn_e reg_fn;
  logic    reg_fn_ok;

  always_comb begin
    reg_fn_ok = 1'b1;
    reg_fn    = ALU_ADD;
    case (funct)
      FN_ADD:  reg_fn = ALU_ADD;
      FN_SUB:  reg_fn = ALU_SUB;
      FN_AND:  reg_fn = ALU_AND;
      FN_OR:   reg_fn = ALU_OR;
      FN_SLT:  reg_fn = ALU_SLT;
      default: reg_fn_ok = 1'b0;
    endcase
  end

  always_comb begin
    ctrl        = '0;
    ctrl.alu_fn = ALU_ADD;
    case (opcode)
      OP_REG: begin
        ctrl.reg_we    = reg_fn_ok;
        ctrl.dst_is_rd = 1'b1;
        ctrl.alu_fn    = reg_fn;
      end
      OP_LOAD: begin
        ctrl.reg_we      = 1'b1;
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      OP_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_fn    = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core import sc_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0]   pc_q, pc_seq, pc_br, pc_nxt;
  logic [5:0]        opcode, funct;
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
  logic [XLEN-1:0]   imm_ext, rs_val, rt_val, alu_b, alu_y, wb_val;
  logic              alu_zero;
  ctrl_t             ctrl;

  assign opcode  = imem_data[31:26];
  assign rs_idx  = imem_data[25:21];
  assign rt_idx  = imem_data[20:16];
  assign rd_idx  = imem_data[15:11];
  assign funct   = imem_data[5:0];
  assign imm_ext = {{(XLEN-16){imem_data[15]}}, imem_data[15:0]};

  sc_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  assign dst_idx = ctrl.dst_is_rd ? rd_idx : rt_idx;

  sc_regfile #(.XLEN(XLEN)) u_rf (
    .clk    (clk),
    .ra_idx (rs_idx),
    .rb_idx (rt_idx),
    .ra_val (rs_val),
    .rb_val (rt_val),
    .wr_en  (ctrl.reg_we && !rst),
    .wr_idx (dst_idx),
    .wr_val (wb_val)
  );

  assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .fn   (ctrl.alu_fn),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign wb_val = ctrl.wb_from_mem ? dmem_rdata : alu_y;

  assign pc_seq = pc_q + STEP;
  assign pc_br  = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
  assign pc_nxt = (ctrl.is_branch && alu_zero) ? pc_br : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we && !rst;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk import sc_pkg::*; #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imem_addr,
  input logic [31:0]     imem_data,
  input logic [XLEN-1:0] dmem_addr,
  input logic [XLEN-1:0] dmem_wdata,
  input logic            dmem_we,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val
);
  logic [5:0]      op;
  logic [XLEN-1:0] sx;
  assign op = imem_data[31:26];
  assign sx = {{(XLEN-16){imem_data[15]}}, imem_data[15:0]};

  AST_PC_CLEARED: assert property (@(posedge clk) rst |=> imem_addr == '0); // R1
  AST_QUIET_IN_RESET: assert property (@(posedge clk) rst |-> !dmem_we); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (op != OP_BEQ) |=> imem_addr == $past(imem_addr) + XLEN'(4)); // R2
  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ && rs_val == rt_val) |=>
      imem_addr == $past(imem_addr) + XLEN'(4) + {$past(sx[XLEN-3:0]), 2'b00}); // R6
  AST_BR_FALL: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ && rs_val != rt_val) |=> imem_addr == $past(imem_addr) + XLEN'(4)); // R6
  AST_STORE_PORTS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_STORE) |-> dmem_we && dmem_wdata == rt_val && dmem_addr == rs_val + sx); // R5
  AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == OP_STORE); // R5
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |-> dmem_addr == rs_val + sx); // R4
  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (imem_data[25:21] == '0) |-> rs_val == '0); // R7
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .imem_data  (imem_data),
  .dmem_addr  (dmem_addr),
  .dmem_wdata (dmem_wdata),
  .dmem_we    (dmem_we),
  .rs_val     (rs_val),
  .rt_val     (rt_val)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem  [64];
  logic [31:0] dmem  [64];
  logic [31:0] dinit [64];
  logic        tb_load = 1'b0;
  logic [5:0]  tb_idx = '0;
  logic [31:0] tb_val = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always_ff @(posedge clk) begin
    if (tb_load)      dmem[tb_idx] <= tb_val;
    else if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] rop(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction
  function automatic logic [31:0] iop(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 64; i++) begin
      imem[i]  = 32'h0;
      dinit[i] = 32'h0;
    end
  endtask

  // holds reset while loading data memory, then releases it on a falling edge
  task automatic start();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      tb_load = 1'b1; tb_idx = 6'(i); tb_val = dinit[i];
      @(negedge clk);
    end
    tb_load = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  localparam int NV = 6;
  logic [31:0] vals [NV];
  logic [5:0]  fns  [5];

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] a, b, exp;
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;

    // R1: reset PC, and a store at PC 0 held in reset must not write
    clear_all();
    for (int i = 0; i < 64; i++) imem[i] = iop(6'h2B, 0, 0, 16'h0008);
    dinit[2] = 32'h55;
    start();
    chk("R1 pc after reset", imem_addr, 32'h0);
    chk("R1 no store in reset", dmem[2], 32'h55);
    run(1);
    chk("R1 store after release", dmem[2], 32'h0);

    // R3 / R2: ALU sweep over all ops and operand pairs
    for (int f = 0; f < 5; f++) begin
      for (int i = 0; i < NV; i++) begin
        for (int j = 0; j < NV; j++) begin
          a = vals[i]; b = vals[j];
          clear_all();
          dinit[0] = a; dinit[1] = b; dinit[2] = 32'hDEAD_BEEF;
          imem[0] = iop(6'h23, 0, 1, 16'h0000);
          imem[1] = iop(6'h23, 0, 2, 16'h0004);
          imem[2] = rop(1, 2, 3, fns[f]);
          imem[3] = iop(6'h2B, 0, 3, 16'h0008);
          start();
          run(4);
          case (f)
            0: exp = a + b;
            1: exp = a - b;
            2: exp = a & b;
            3: exp = a | b;
            default: exp = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          endcase
          chk($sformatf("R3 fn=%h a=%h b=%h", fns[f], a, b), dmem[2], exp);
          if (f == 0 && i == 0 && j == 0) chk("R2 pc after 4 steps", imem_addr, 32'd16);
        end
      end
    end

    // R9: read-and-write same register, then dependent read
    clear_all();
    dinit[0] = 32'd7;
    imem[0] = iop(6'h23, 0, 1, 16'h0000);
    imem[1] = rop(1, 1, 1, 6'h20);
    imem[2] = rop(1, 1, 2, 6'h20);
    imem[3] = iop(6'h2B, 0, 1, 16'h0008);
    imem[4] = iop(6'h2B, 0, 2, 16'h000C);
    start();
    run(5);
    chk("R9 self update", dmem[2], 32'd14);
    chk("R9 next sees new", dmem[3], 32'd28);

    // R7: register 0 stays zero
    clear_all();
    dinit[0] = 32'h1234; dinit[2] = 32'hFFFF; dinit[3] = 32'hFFFF;
    imem[0] = iop(6'h23, 0, 0, 16'h0000);
    imem[1] = iop(6'h23, 0, 1, 16'h0000);
    imem[2] = rop(1, 1, 0, 6'h20);
    imem[3] = iop(6'h2B, 0, 0, 16'h0008);
    imem[4] = rop(0, 1, 3, 6'h20);
    imem[5] = iop(6'h2B, 0, 3, 16'h000C);
    start();
    run(6);
    chk("R7 r0 reads zero", dmem[2], 32'h0);
    chk("R7 r0 as operand", dmem[3], 32'h1234);

    // R4 / R5: negative offsets; store leaves registers alone
    clear_all();
    dinit[4] = 32'd40; dinit[9] = 32'hCAFE; dinit[1] = 32'd5;
    imem[0] = iop(6'h23, 0, 4, 16'h0010);
    imem[1] = iop(6'h23, 4, 1, 16'hFFFC);
    imem[2] = iop(6'h2B, 4, 1, 16'hFFF8);
    imem[3] = iop(6'h23, 0, 2, 16'h0004);
    imem[4] = iop(6'h2B, 0, 2, 16'h0810);
    imem[5] = iop(6'h2B, 0, 1, 16'h000C);
    start();
    run(6);
    chk("R4 load base minus offset", dmem[8], 32'hCAFE);
    chk("R5 store wrapped addr", dmem[4], 32'd5);
    chk("R5 store no reg write", dmem[3], 32'hCAFE);

    // R6: branch sweep, taken when equal
    for (int i = 0; i < NV; i++) begin
      for (int j = 0; j < NV; j++) begin
        clear_all();
        dinit[0] = vals[i]; dinit[1] = vals[j];
        dinit[2] = 32'hDEAD; dinit[3] = 32'hDEAD;
        imem[0] = iop(6'h23, 0, 1, 16'h0000);
        imem[1] = iop(6'h23, 0, 2, 16'h0004);
        imem[2] = iop(6'h04, 1, 2, 16'h0001);
        imem[3] = iop(6'h2B, 0, 1, 16'h0008);
        imem[4] = iop(6'h2B, 0, 2, 16'h000C);
        start();
        run(3);
        chk($sformatf("R6 pc a=%h b=%h", vals[i], vals[j]), imem_addr,
            (vals[i] == vals[j]) ? 32'd16 : 32'd12);
        run(2);
        chk($sformatf("R6 skip a=%h b=%h", vals[i], vals[j]), dmem[2],
            (vals[i] == vals[j]) ? 32'hDEAD : vals[i]);
      end
    end

    // R6: backward branch to itself holds the PC
    clear_all();
    imem[0] = iop(6'h04, 0, 0, 16'hFFFF);
    start();
    run(3);
    chk("R6 self loop", imem_addr, 32'h0);

    // R8: unlisted opcode and function are ignored
    clear_all();
    dinit[0] = 32'd9;
    imem[0] = iop(6'h23, 0, 1, 16'h0000);
    imem[1] = iop(6'h08, 0, 1, 16'h0005);
    imem[2] = rop(0, 0, 1, 6'h21);
    imem[3] = iop(6'h2B, 0, 1, 16'h0008);
    start();
    run(3);
    chk("R8 pc advances", imem_addr, 32'd12);
    run(1);
    chk("R8 no reg write", dmem[2], 32'd9);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule